// File: doc/BRIEF.md
# Sixteen-bit GPIO Expander Register Bank

This block holds the registers of a two-port, sixteen-pin general purpose I/O expander and sits behind a byte-level serial-bus target. The target reports four events to it: a transaction start, a received byte, a request for the next byte to send, and a stop. After a start, the first byte received is a command byte that loads a register pointer. Later bytes in the same transaction are written to the selected register, or read from it. After each data byte the pointer steps to the other register of its port pair, so sixteen-bit bursts need only one command byte.

Each pin has a direction bit, an output value bit and a polarity bit. A pin whose direction bit is set is an input and its driver is disabled. A pin whose direction bit is clear drives its output register bit. The input registers report the synchronized level of every pin, XORed with the polarity bits, whatever the pin's direction. The output registers read back their stored value, not the pin level. The pointer survives a stop, so a read transaction with no command byte continues from the last selected register.

Top module: `gpio16_regbank`

## Requirements
- R1: After reset, both output registers read 0xFF, both polarity registers read 0x00, both direction registers read 0xFF, `pin_oe` is all zero, `pin_out` is all zero and `host_rd_data` is 0x00.
- R2: The first byte received after a start loads the pointer from its three low bits and ignores the upper five. Pointer values 0 to 7 select input port 0, input port 1, output port 0, output port 1, polarity port 0, polarity port 1, direction port 0 and direction port 1.
- R3: A data byte written while the pointer selects input port 0 or 1 changes no register and no pin. The pointer still steps.
- R4: An input register reports every pin of its port, outputs included, through a two-stage synchronizer. A read request captures the level that `pin_in` held two rising edges before the request's edge.
- R5: Reading an output register returns the stored byte, whatever level is on the pins.
- R6: Bit i of `pin_oe` is 1 exactly when direction bit i is 0. Bit i of `pin_out` equals output bit i on driven pins and is 0 on input pins. A write changes the pins on the edge that accepts the byte.
- R7: A polarity bit of 1 inverts the reported input bit and a polarity bit of 0 leaves it unchanged.
- R8: After each data byte written or read, the pointer moves to the other register of its pair (0↔1, 2↔3, 4↔5, 6↔7).
- R9: A stop leaves the pointer unchanged, so a read after a new start with no command byte returns the register that follows the last one accessed.
- R10: `host_rd_data` is registered. It changes only on the edge that accepts a read request and then holds its value.
- R11: A start and a received byte in the same cycle make that byte the command byte. A received byte and a read request in the same cycle perform the write only: the read is dropped, `host_rd_data` holds its value and the pointer steps once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_start | input | 1 | One-cycle pulse: a transaction begins |
| host_stop | input | 1 | One-cycle pulse: the transaction ends |
| host_wr_valid | input | 1 | One-cycle pulse: `host_wr_data` holds a received byte |
| host_wr_data | input | 8 | Received byte |
| host_rd_req | input | 1 | One-cycle pulse: the target wants the next byte to send |
| host_rd_data | output | 8 | Byte to send, valid from the cycle after the request |
| pin_in | input | 16 | Sampled pin levels, port 1 in the upper byte |
| pin_out | output | 16 | Output value per pin, port 1 in the upper byte |
| pin_oe | output | 16 | Output driver enable per pin, port 1 in the upper byte |

## Verification
Two pairs of host events can coincide in one cycle. A start can arrive together with the byte it precedes, and a received byte can arrive together with a read request. The bench drives both cases on purpose. It checks that the coincident byte loads the pointer, and that the write wins while the read data stays put. The pointer must step only once, and the bench checks this through the register returned by the following read. A pin change that lands on the same edge as a read request also has to return the old level. The behavioural reference model tracks the synchronizer delay and checks the read data and both pin vectors on every cycle.

// File: rtl/gpx_pkg.sv
// Package gpx_pkg
// Shared types of the GPIO expander register bank. A register pointer is
// {kind, port}: the kind picks the register class and the port picks the byte
// lane. With two ports this puts the classes at pointer values 0-1, 2-3, 4-5
// and 6-7.
package gpx_pkg;
    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_IN  = 2'd0,
        KIND_OUT = 2'd1,
        KIND_POL = 2'd2,
        KIND_DIR = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/gpx_sync.sv
// Module gpx_sync
// Two-flop synchronizer for the sampled pin levels.
// Assumes: each bit is treated on its own. No bus coherence is promised
// across bits that change in the same cycle.
module gpx_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1_q;

    // Move the pin levels through the two synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q        <= '0;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end
endmodule

// File: rtl/gpx_cmd_ctrl.sv
// Module gpx_cmd_ctrl
// Decodes the host byte events. It tracks whether the next received byte is a
// command byte and holds the register pointer. It issues one data-write or
// data-read strobe per accepted byte and steps the port field of the pointer
// after each of them.
// Assumes: PORTS is a power of two, so the port field wraps inside its pair.
// A received byte takes priority over a read request in the same cycle.
module gpx_cmd_ctrl #(
    parameter int PORTS = 2,
    localparam int PB    = $clog2(PORTS),
    localparam int PTR_W = gpx_pkg::KIND_W + PB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             wr_valid,
    input  logic [PTR_W-1:0] cmd_bits,
    input  logic             rd_req,
    output logic [PTR_W-1:0] ptr_q,
    output logic             armed_q,
    output logic             data_wr,
    output logic             data_rd
);
    logic             cmd_take;
    logic [PB-1:0]    port_next;

    // Sort the current byte event into command, data write or data read.
    always_comb begin
        cmd_take  = wr_valid & (start | armed_q);
        data_wr   = wr_valid & ~(start | armed_q);
        data_rd   = rd_req & ~wr_valid;
        port_next = ptr_q[PB-1:0] + 1'b1;
    end

    // Keep the command-expected flag: set by a start, cleared by a byte or a stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (start && !wr_valid) begin
            armed_q <= 1'b1;
        end else if (wr_valid || stop) begin
            armed_q <= 1'b0;
        end
    end

    // Load the pointer from a command byte, or step it within its pair after a data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (cmd_take) begin
            ptr_q <= cmd_bits;
        end else if (data_wr || data_rd) begin
            ptr_q <= {ptr_q[PTR_W-1:PB], port_next};
        end
    end
endmodule

// File: rtl/gpx_regfile.sv
// Module gpx_regfile
// Holds the writable registers: output value, polarity and direction, one
// byte of each per port. The input class has no storage here, so a write that
// selects it falls through without effect.
// Assumes: wr_en is a single-cycle strobe and wr_idx is a valid pointer.
module gpx_regfile #(
    parameter int PORTS  = 2,
    parameter int PORT_W = 8,
    localparam int PB    = $clog2(PORTS),
    localparam int PTR_W = gpx_pkg::KIND_W + PB,
    localparam int ALL_W = PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [PORT_W-1:0] wr_byte,
    output logic [ALL_W-1:0]  out_vec,
    output logic [ALL_W-1:0]  pol_vec,
    output logic [ALL_W-1:0]  dir_vec
);
    import gpx_pkg::*;

    reg_kind_e     wr_kind;
    logic [PB-1:0] wr_port;

    // Split the write index into register class and port lane.
    always_comb begin
        wr_kind = reg_kind_e'(wr_idx[PTR_W-1:PB]);
        wr_port = wr_idx[PB-1:0];
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic hit;

        // Decide whether this cycle's write targets this port's lane.
        always_comb hit = wr_en && (wr_port == PB'(p));

        // Update this port's writable registers; all pins come out of reset as inputs.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_vec[p*PORT_W +: PORT_W] <= '1;
                pol_vec[p*PORT_W +: PORT_W] <= '0;
                dir_vec[p*PORT_W +: PORT_W] <= '1;
            end else if (hit) begin
                case (wr_kind)
                    KIND_OUT: out_vec[p*PORT_W +: PORT_W] <= wr_byte;
                    KIND_POL: pol_vec[p*PORT_W +: PORT_W] <= wr_byte;
                    KIND_DIR: dir_vec[p*PORT_W +: PORT_W] <= wr_byte;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio16_regbank.sv
// Module gpio16_regbank
// Register bank of a two-port GPIO expander behind a byte-level bus target.
// It ties the event decoder, the register file and the pin synchronizer
// together, selects the read byte and drives the pin enables and values.
// Assumes: the bus target gives at most one of start/stop per cycle and holds
// host_wr_data valid while host_wr_valid is high.
module gpio16_regbank #(
    parameter int PORTS  = 2,
    parameter int PORT_W = 8,
    localparam int PB    = $clog2(PORTS),
    localparam int PTR_W = gpx_pkg::KIND_W + PB,
    localparam int ALL_W = PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_start,
    input  logic              host_stop,
    input  logic              host_wr_valid,
    input  logic [PORT_W-1:0] host_wr_data,
    input  logic              host_rd_req,
    output logic [PORT_W-1:0] host_rd_data,
    input  logic [ALL_W-1:0]  pin_in,
    output logic [ALL_W-1:0]  pin_out,
    output logic [ALL_W-1:0]  pin_oe
);
    import gpx_pkg::*;

    logic [PTR_W-1:0]  ptr_q;
    logic              armed_q;
    logic              data_wr;
    logic              data_rd;
    logic [ALL_W-1:0]  out_vec;
    logic [ALL_W-1:0]  pol_vec;
    logic [ALL_W-1:0]  dir_vec;
    logic [ALL_W-1:0]  pin_sync;
    logic [ALL_W-1:0]  in_view;
    logic [PORT_W-1:0] rd_mux;
    reg_kind_e         rd_kind;
    logic [PB-1:0]     rd_port;

    gpx_cmd_ctrl #(.PORTS(PORTS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (host_start),
        .stop     (host_stop),
        .wr_valid (host_wr_valid),
        .cmd_bits (host_wr_data[PTR_W-1:0]),
        .rd_req   (host_rd_req),
        .ptr_q    (ptr_q),
        .armed_q  (armed_q),
        .data_wr  (data_wr),
        .data_rd  (data_rd)
    );

    gpx_regfile #(.PORTS(PORTS), .PORT_W(PORT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_wr),
        .wr_idx  (ptr_q),
        .wr_byte (host_wr_data),
        .out_vec (out_vec),
        .pol_vec (pol_vec),
        .dir_vec (dir_vec)
    );

    gpx_sync #(.WIDTH(ALL_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    // Drive the pins: enabled where the direction bit is clear, value gated to driven pins.
    always_comb begin
        pin_oe  = ~dir_vec;
        pin_out = out_vec & ~dir_vec;
        in_view = pin_sync ^ pol_vec;
    end

    // Select the byte named by the pointer for the next read.
    always_comb begin
        rd_kind = reg_kind_e'(ptr_q[PTR_W-1:PB]);
        rd_port = ptr_q[PB-1:0];
        case (rd_kind)
            KIND_IN:  rd_mux = in_view[rd_port*PORT_W +: PORT_W];
            KIND_OUT: rd_mux = out_vec[rd_port*PORT_W +: PORT_W];
            KIND_POL: rd_mux = pol_vec[rd_port*PORT_W +: PORT_W];
            default:  rd_mux = dir_vec[rd_port*PORT_W +: PORT_W];
        endcase
    end

    // Capture the read byte when it is requested, so it holds while shifted out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rd_data <= '0;
        end else if (data_rd) begin
            host_rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/gpx_regbank_chk.sv
// Module gpx_regbank_chk
// Property checker for gpio16_regbank, attached through the bind below.
// Assumes: it sees the top's pointer and command-expected flag.
module gpx_regbank_chk #(
    parameter int PORTS  = 2,
    parameter int PORT_W = 8,
    localparam int PB    = $clog2(PORTS),
    localparam int PTR_W = gpx_pkg::KIND_W + PB,
    localparam int ALL_W = PORTS * PORT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_start,
    input logic              host_stop,
    input logic              host_wr_valid,
    input logic [PORT_W-1:0] host_wr_data,
    input logic              host_rd_req,
    input logic [PORT_W-1:0] host_rd_data,
    input logic [ALL_W-1:0]  pin_out,
    input logic [ALL_W-1:0]  pin_oe,
    input logic [PTR_W-1:0]  ptr_q,
    input logic              armed_q
);
    logic [PB-1:0] port_step;

    // Port lane that a data byte moves the pointer to.
    always_comb port_step = ptr_q[PB-1:0] + 1'b1;

    AST_CMD_LOADS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_valid && (host_start || armed_q)) |=> (ptr_q == $past(host_wr_data[PTR_W-1:0]))); // R2

    AST_INPUT_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_valid && !host_start && !armed_q && ptr_q[PTR_W-1:PB] == '0)
        |=> ($stable(pin_out) && $stable(pin_oe))); // R3

    AST_PTR_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_req && !host_wr_valid)
        |=> (ptr_q[PTR_W-1:PB] == $past(ptr_q[PTR_W-1:PB]) && ptr_q[PB-1:0] == $past(port_step))); // R8

    AST_STOP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stop && !host_wr_valid && !host_rd_req) |=> $stable(ptr_q)); // R9

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd_req && !host_wr_valid) |=> $stable(host_rd_data)); // R10
endmodule

bind gpio16_regbank gpx_regbank_chk #(.PORTS(PORTS), .PORT_W(PORT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_start    (host_start),
    .host_stop     (host_stop),
    .host_wr_valid (host_wr_valid),
    .host_wr_data  (host_wr_data),
    .host_rd_req   (host_rd_req),
    .host_rd_data  (host_rd_data),
    .pin_out       (pin_out),
    .pin_oe        (pin_oe),
    .ptr_q         (ptr_q),
    .armed_q       (armed_q)
);

// File: tb/gpio16_regbank_test.sv
// Bench for gpio16_regbank: directed sequences checked against expected bytes,
// plus a behavioural reference model compared on every clock.
module gpio16_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_start = 1'b0;
    logic        host_stop = 1'b0;
    logic        host_wr_valid = 1'b0;
    logic [7:0]  host_wr_data = 8'h00;
    logic        host_rd_req = 1'b0;
    logic [7:0]  host_rd_data;
    logic [15:0] pin_in = 16'h0000;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;

    // reference model state
    logic [7:0]  m_reg [8];
    int          m_ptr;
    bit          m_arm;
    logic [7:0]  m_rd;
    logic [15:0] m_s1, m_s2;

    gpio16_regbank uut (
        .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_stop(host_stop),
        .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
        .host_rd_req(host_rd_req), .host_rd_data(host_rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #2 clk = ~clk;

    // reference model: advances on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF};
            m_ptr = 0; m_arm = 1'b0; m_rd = 8'h00; m_s1 = '0; m_s2 = '0;
        end else begin
            if (host_wr_valid) begin
                if (host_start || m_arm) m_ptr = host_wr_data % 8;
                else begin
                    if (m_ptr >= 2) m_reg[m_ptr] = host_wr_data;
                    m_ptr = m_ptr ^ 1;
                end
            end else if (host_rd_req) begin
                if (m_ptr < 2) m_rd = m_s2[m_ptr*8 +: 8] ^ m_reg[4 + m_ptr];
                else m_rd = m_reg[m_ptr];
                m_ptr = m_ptr ^ 1;
            end
            if (host_wr_valid || host_stop) m_arm = 1'b0;
            if (host_start && !host_wr_valid) m_arm = 1'b1;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    // compare design and model away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            checks++;
            if (host_rd_data !== m_rd) begin
                fails++;
                $display("FAIL R4/R5/R10 model rd_data act=%h exp=%h", host_rd_data, m_rd);
            end
            checks++;
            if (pin_oe !== ~{m_reg[7], m_reg[6]}) begin
                fails++;
                $display("FAIL R6 model pin_oe act=%h exp=%h", pin_oe, ~{m_reg[7], m_reg[6]});
            end
            checks++;
            if (pin_out !== ({m_reg[3], m_reg[2]} & ~{m_reg[7], m_reg[6]})) begin
                fails++;
                $display("FAIL R6 model pin_out act=%h exp=%h", pin_out,
                         {m_reg[3], m_reg[2]} & ~{m_reg[7], m_reg[6]});
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog act=%0d exp<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic st, input logic sp, input logic wv,
                         input logic [7:0] d, input logic rr);
        @(negedge clk);
        host_start = st; host_stop = sp; host_wr_valid = wv; host_wr_data = d; host_rd_req = rr;
        @(negedge clk);
        host_start = 1'b0; host_stop = 1'b0; host_wr_valid = 1'b0; host_rd_req = 1'b0;
    endtask

    task automatic t_start;  pulse(1'b1, 1'b0, 1'b0, 8'h00, 1'b0); endtask
    task automatic t_stop;   pulse(1'b0, 1'b1, 1'b0, 8'h00, 1'b0); endtask
    task automatic t_wr(input logic [7:0] d); pulse(1'b0, 1'b0, 1'b1, d, 1'b0); endtask
    task automatic t_rd(output logic [7:0] v);
        pulse(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
        v = host_rd_data;
    endtask
    task automatic t_cmd(input logic [7:0] c); t_start(); t_wr(c); endtask

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 16'h0000);
        chk("R1 pin_out", pin_out, 16'h0000);
        chk("R1 rd_data", {8'h00, host_rd_data}, 16'h0000);
        t_cmd(8'h02); t_rd(v); chk("R1 out0", {8'h00, v}, 16'h00FF);
        t_rd(v); chk("R1 R8 out1", {8'h00, v}, 16'h00FF); t_stop();
        t_cmd(8'h04); t_rd(v); chk("R1 pol0", {8'h00, v}, 16'h0000);
        t_rd(v); chk("R1 pol1", {8'h00, v}, 16'h0000); t_stop();
        t_cmd(8'h06); t_rd(v); chk("R1 dir0", {8'h00, v}, 16'h00FF);
        t_rd(v); chk("R1 dir1", {8'h00, v}, 16'h00FF); t_stop();
        // R6 R8 burst writes to direction and output
        t_cmd(8'h06); t_wr(8'h0F); t_wr(8'hF0); t_stop();
        chk("R6 oe", pin_oe, 16'h0FF0);
        t_cmd(8'h02); t_wr(8'hA5); t_wr(8'h3C); t_stop();
        chk("R6 out", pin_out, 16'h0CA0);
        // R5 output readback ignores pins
        pin_in = 16'h0000;
        t_cmd(8'h02); t_rd(v); chk("R5 out0", {8'h00, v}, 16'h00A5); t_stop();
        // R4 input reports all pins, R7 polarity
        pin_in = 16'h1234;
        repeat (3) @(negedge clk);
        t_cmd(8'h00); t_rd(v); chk("R4 in0", {8'h00, v}, 16'h0034);
        t_rd(v); chk("R4 in1", {8'h00, v}, 16'h0012); t_stop();
        t_cmd(8'h04); t_wr(8'hFF); t_wr(8'h0F); t_stop();
        t_cmd(8'h00); t_rd(v); chk("R7 in0", {8'h00, v}, 16'h00CB);
        t_rd(v); chk("R7 in1", {8'h00, v}, 16'h001D); t_stop();
        // R3 writes to input registers dropped, pointer still steps
        t_cmd(8'h01); t_wr(8'h00); t_wr(8'h77); t_stop();
        chk("R3 pin_out", pin_out, 16'h0CA0);
        chk("R3 pin_oe", pin_oe, 16'h0FF0);
        // R9 pointer kept across stop: next read hits input 1
        t_start(); t_rd(v); chk("R9 R3 in1", {8'h00, v}, 16'h001D); t_stop();
        t_start(); t_rd(v); chk("R9 in0", {8'h00, v}, 16'h00CB); t_stop();
        // R11 start and command byte in the same cycle
        pulse(1'b1, 1'b0, 1'b1, 8'h03, 1'b0);
        t_rd(v); chk("R11 cmd with start", {8'h00, v}, 16'h003C);
        // R11 write and read in the same cycle: write wins, read dropped
        pulse(1'b0, 1'b0, 1'b1, 8'h11, 1'b1);
        chk("R11 R10 rd held", {8'h00, host_rd_data}, 16'h003C);
        chk("R11 write done", pin_out, 16'h0C10);
        t_rd(v); chk("R11 single step", {8'h00, v}, 16'h003C);
        t_rd(v); chk("R11 out0", {8'h00, v}, 16'h0011); t_stop();
        // R2 upper command bits ignored
        t_cmd(8'hFE); t_rd(v); chk("R2 upper bits", {8'h00, v}, 16'h000F); t_stop();
        // R4 synchronizer: pin change on the request edge returns the old level
        pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        t_cmd(8'h00);
        @(negedge clk); pin_in = 16'h00AA; host_rd_req = 1'b1;
        @(negedge clk); host_rd_req = 1'b0;
        chk("R4 sync old", {8'h00, host_rd_data}, 16'h00FF);
        t_stop();
        repeat (3) @(negedge clk);
        t_cmd(8'h00); t_rd(v); chk("R4 sync new", {8'h00, v}, 16'h0055); t_stop();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule